// File: doc/BRIEF.md
# Strobed Serial Configuration Port

This block is the slave end of a four-wire serial command link. An external controller writes configuration registers and reads back buffer status flags through it. The four wires are an active-low select, a bit strobe, a data line into the block and a data line out of it. The strobe is not a free-running clock. Each pulse marks exactly one bit, and the gaps between pulses may be long and uneven. All three incoming lines are brought into the system clock domain by two-flop synchronizers. Bits are taken only on the synchronized rising edge of the strobe, so elapsed time has no effect on what is received.

While select is low, incoming bits are shifted most-significant first into a byte. The first byte of each pair is a register address and the second is the data for it. When the data byte is complete, the block raises a single-cycle write pulse on a parallel address/data bus, and that pulse updates a small register bank held inside the block. At the same time, a status byte goes back to the controller on the outgoing line. The block captures that byte from its status input at the moment select falls, so the flags cannot change in the middle of a transfer.

Top module: `strobe_cfg_port`

## Requirements
- R1: After reset, `sdo_o` and `wr_pulse_o` are 0 and every register in the bank reads 0.
- R2: While select is low, each synchronized rising edge of `stb_i` shifts the current `sdi_i` into the receive byte, most-significant bit first. Uneven spacing between strobes changes nothing.
- R3: Within one select-low period, bytes alternate address, data, address, data and so on. After each data byte, `wr_pulse_o` is high for exactly one cycle, with `wr_addr_o` set to the preceding address byte and `wr_data_o` set to the data byte.
- R4: When select falls, the block latches `status_i`, and `sdo_o` shows bit 7 of it. Each strobe rising edge advances `sdo_o` to the next lower bit. The same latched byte is sent again for every byte of the frame, even if `status_i` changes during the frame.
- R5: If select rises before the eighth bit of a byte, the partial byte is discarded and no write pulse is produced. The next frame starts with an address byte.
- R6: A write pulse whose address is below `NREGS` stores the data in that register. The register appears on `regs_o` at bits [addr*8+7 : addr*8].
- R7: A write pulse whose address is `NREGS` or above leaves every register unchanged. The address is compared as a full 8-bit value, so upper bits are not ignored.
- R8: Strobe edges while select is high shift nothing and produce no write pulse. The next frame's first byte is still taken as an address.
- R9: While select is high, `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Frame select from the controller, low during a transfer (asynchronous) |
| stb_i | input | 1 | Bit strobe, one pulse per bit (asynchronous) |
| sdi_i | input | 1 | Serial data from the controller (asynchronous) |
| sdo_o | output | 1 | Serial status data to the controller |
| status_i | input | 8 | Buffer full/empty flags to report |
| wr_pulse_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Address of the write |
| wr_data_o | output | 8 | Data of the write |
| regs_o | output | NREGS*8 | Contents of the register bank, register 0 in the low byte |

## Verification
Two functions can act in the same frame period: the end of a byte, which reloads the outgoing shift register and may fire a write, and the status capture at a select fall. The riskiest interaction is a select rise close to the eighth strobe. The bench provokes it by aborting frames after one to seven bits and then sending a full frame. It judges the result by the write-pulse count, by the bank contents at the ports, and by whether the next address lands on the expected register. It also changes `status_i` in the middle of every frame and checks that each returned byte still equals the value present at the select fall.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} phase_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, out_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[g];
        out_q  <= RST_VAL[g];
      end else begin
        meta_q <= d_i[g];
        out_q  <= meta_q;
      end
    end
    assign q_o[g] = out_q;
  end
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_s,
  input  logic         stb_s,
  input  logic         sdi_s,
  input  logic [W-1:0] status_i,
  output logic         sdo_o,
  output logic         done_o,
  output logic [W-1:0] byte_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          stb_d, sel_d;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rx_q, tx_q, stat_q;
  logic          stb_rise, sel_fall;
  logic [W-1:0]  rx_next;

  assign stb_rise = stb_s & ~stb_d;
  assign sel_fall = ~sel_s & sel_d;
  assign rx_next  = {rx_q[W-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_d  <= 1'b0;
      sel_d  <= 1'b1;
      cnt    <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      stat_q <= '0;
      done_o <= 1'b0;
      byte_o <= '0;
    end else begin
      stb_d  <= stb_s;
      sel_d  <= sel_s;
      done_o <= 1'b0;
      if (sel_s) begin
        cnt  <= '0;
        tx_q <= '0;
      end else if (sel_fall) begin
        stat_q <= status_i;
        tx_q   <= status_i;
        cnt    <= '0;
      end else if (stb_rise) begin
        rx_q <= rx_next;
        if (cnt == LAST) begin
          cnt    <= '0;
          done_o <= 1'b1;
          byte_o <= rx_next;
          tx_q   <= stat_q;
        end else begin
          cnt  <= cnt + 1'b1;
          tx_q <= {tx_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_o = tx_q[W-1];

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && !sel_fall && !stb_rise) |=> $stable(tx_q));
  // R5
  abort_nodone_chk: assert property (@(posedge clk) disable iff (rst)
    sel_s |=> (!done_o && cnt == '0));
  // R9
  idle_sdo_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sel_s) |-> !sdo_o);
endmodule

// File: rtl/scp_bank.sv
module scp_bank #(
  parameter int W     = 8,
  parameter int NREGS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [W-1:0]     addr_i,
  input  logic [W-1:0]     data_i,
  output logic [NREGS*W-1:0] regs_o
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [NREGS-1:0][W-1:0] mem;
  logic                    hit;

  assign hit = we_i && (int'(addr_i) < NREGS);

  always_ff @(posedge clk) begin
    if (rst) mem <= '0;
    else if (hit) mem[addr_i[IW-1:0]] <= data_i;
  end

  assign regs_o = mem;

  // R7
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(mem));
  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> mem[$past(addr_i[IW-1:0])] == $past(data_i));
endmodule

// File: rtl/strobe_cfg_port.sv
module strobe_cfg_port
  import scp_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_n_i,
  input  logic               stb_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  input  logic [7:0]         status_i,
  output logic               wr_pulse_o,
  output logic [7:0]         wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic [NREGS*8-1:0] regs_o
);
  localparam int W = 8;

  logic          sel_s, stb_s, sdi_s;
  logic [1:0]    dsync;
  logic          done;
  logic [W-1:0]  rx_byte, addr_q;
  phase_t        phase;

  scp_sync #(.W(1), .RST_VAL(1'b1)) u_sel_sync (
    .clk(clk), .rst(rst), .d_i(sel_n_i), .q_o(sel_s));
  scp_sync #(.W(2), .RST_VAL(2'b00)) u_dat_sync (
    .clk(clk), .rst(rst), .d_i({stb_i, sdi_i}), .q_o(dsync));
  assign stb_s = dsync[1];
  assign sdi_s = dsync[0];

  scp_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .sel_s(sel_s), .stb_s(stb_s), .sdi_s(sdi_s),
    .status_i(status_i), .sdo_o(sdo_o), .done_o(done), .byte_o(rx_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_ADDR;
      addr_q     <= '0;
      wr_pulse_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_pulse_o <= 1'b0;
      if (done) begin
        if (phase == PH_ADDR) begin
          addr_q <= rx_byte;
          phase  <= PH_DATA;
        end else begin
          wr_pulse_o <= 1'b1;
          wr_addr_o  <= addr_q;
          wr_data_o  <= rx_byte;
          phase      <= PH_ADDR;
        end
      end else if (sel_s) begin
        phase <= PH_ADDR;
      end
    end
  end

  scp_bank #(.W(W), .NREGS(NREGS)) u_bank (
    .clk(clk), .rst(rst), .we_i(wr_pulse_o), .addr_i(wr_addr_o),
    .data_i(wr_data_o), .regs_o(regs_o));

  // R3
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pulse_o |=> !wr_pulse_o);
  // R3
  pulse_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_pulse_o) |-> $past(done));
  // R8
  idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_s && !done) |=> phase == PH_ADDR);
endmodule

// File: tb/strobe_cfg_port_bench.sv
module strobe_cfg_port_bench;
  localparam int NREGS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, stb = 1'b0, sdi = 1'b0;
  logic [7:0] status = 8'h00;
  logic sdo, wr_pulse;
  logic [7:0] wr_addr, wr_data;
  logic [NREGS*8-1:0] regs;

  int checks = 0, fails = 0;
  int pulses = 0, wide = 0;
  logic prev_pulse = 1'b0;
  logic [7:0] last_addr = 8'h00, last_data = 8'h00;
  logic [7:0] model [NREGS];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  strobe_cfg_port #(.NREGS(NREGS)) u_strobe_cfg_port (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .stb_i(stb), .sdi_i(sdi),
    .sdo_o(sdo), .status_i(status), .wr_pulse_o(wr_pulse),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .regs_o(regs));

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_pulse) begin
        pulses++;
        last_addr = wr_addr;
        last_data = wr_data;
        if (prev_pulse) wide++;
      end
      prev_pulse = wr_pulse;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame_start(input logic [7:0] st);
    status = st;
    sel_n = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic frame_end();
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nbits, input int seed,
                           output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      sdi = tx[i];
      rx[i] = sdo;
      repeat (2 + ((i + seed) % 5)) @(negedge clk);
      stb = 1'b1;
      repeat (3 + (i % 2)) @(negedge clk);
      stb = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic check_bank(input string req);
    for (int a = 0; a < NREGS; a++)
      check(regs[a*8 +: 8] == model[a], req, regs[a*8 +: 8], model[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1, st;
    int p0;
    for (int a = 0; a < NREGS; a++) model[a] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sdo == 1'b0, "R1 sdo", sdo, 0);
    check(wr_pulse == 1'b0, "R1 pulse", wr_pulse, 0);
    check(regs == '0, "R1 bank", regs, 0);

    // R2 R3 R4 R6 R7: sweep addresses 0..7 with varied data and status
    for (int a = 0; a < 8; a++) begin
      logic [7:0] d;
      d  = 8'((a * 37 + 11) ^ (a << 5));
      st = 8'(a * 29 + 3);
      p0 = pulses;
      frame_start(st);
      send_bits(8'(a), 8, a, r0);
      status = ~st;  // mid-frame change must not be seen (R4)
      send_bits(d, 8, a + 2, r1);
      frame_end();
      check(r0 == st, "R4 first byte status", r0, st);
      check(r1 == st, "R4 second byte status", r1, st);
      check(pulses == p0 + 1, "R3 one pulse per pair", pulses - p0, 1);
      check(last_addr == 8'(a) && last_data == d, "R2 R3 addr/data",
            {last_addr, last_data}, {8'(a), d});
      if (a < NREGS) model[a] = d;
      check_bank(a < NREGS ? "R6 bank write" : "R7 out-of-range ignored");
    end
    check(wide == 0, "R3 pulse width", wide, 0);

    // R7: high address bit set must not alias onto register 1
    frame_start(8'h5A);
    send_bits(8'h81, 8, 1, r0);
    send_bits(8'hEE, 8, 3, r1);
    frame_end();
    check_bank("R7 upper bits compared");

    // R3: two pairs in one frame
    p0 = pulses;
    frame_start(8'hC3);
    send_bits(8'h02, 8, 0, r0);
    send_bits(8'h6D, 8, 1, r1);
    send_bits(8'h03, 8, 2, r0);
    send_bits(8'h91, 8, 4, r1);
    frame_end();
    model[2] = 8'h6D; model[3] = 8'h91;
    check(pulses == p0 + 2, "R3 two pairs", pulses - p0, 2);
    check(r1 == 8'hC3, "R4 fourth byte status", r1, 8'hC3);
    check_bank("R3 two pairs bank");

    // R5: abort after 1..7 bits, and mid data byte
    for (int n = 1; n < 8; n++) begin
      p0 = pulses;
      frame_start(8'h0F);
      send_bits(8'h01, 8, n, r0);
      send_bits(8'hFF, n, n, r1);
      frame_end();
      check(pulses == p0, "R5 partial data discarded", pulses - p0, 0);
      check_bank("R5 bank unchanged");
      p0 = pulses;
      frame_start(8'h0F);
      send_bits(8'h02, n, n, r0);
      frame_end();
      frame_start(8'h0F);
      send_bits(8'h00, 8, n, r0);
      send_bits(8'(n * 17), 8, n + 1, r1);
      frame_end();
      model[0] = 8'(n * 17);
      check(pulses == p0 + 1 && last_addr == 8'h00, "R5 restart at address",
            last_addr, 0);
      check_bank("R5 restart bank");
    end

    // R8 R9: strobes while select is high
    p0 = pulses;
    send_bits(8'hA5, 5, 0, r0);
    check(r0 == 8'h00, "R9 sdo idle", r0, 0);
    check(pulses == p0, "R8 idle strobes", pulses - p0, 0);
    frame_start(8'h77);
    send_bits(8'h01, 8, 2, r0);
    send_bits(8'h3C, 8, 3, r1);
    frame_end();
    model[1] = 8'h3C;
    check(last_addr == 8'h01 && r0 == 8'h77, "R8 alignment kept", last_addr, 1);
    check_bank("R8 bank");
    check(sdo == 1'b0, "R9 sdo after frame", sdo, 0);
    check(wide == 0, "R3 pulse width final", wide, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule